// File: doc/BRIEF.md
# Base-Integer Instruction Decoder

This block turns one 32-bit instruction word of the 64-bit base integer set into the control fields the rest of a pipeline needs. It reports the instruction class, an operation code within that class, the three register index fields, a 64-bit immediate assembled and sign-extended according to the encoding format, the predecessor and successor ordering sets of a memory fence, a destination-write enable and an illegal-instruction flag. It is purely combinational and sits between fetch and register read.

Every word that does not match a defined pattern is flagged illegal. In that case the decoder reports no class, no operation and a zero immediate, and it enables no register write. Downstream logic can therefore treat an illegal word as a bubble and raise its own exception from the flag. Reading registers and carrying out the operation are left to other stages.

Top module: `rvdec_top`

## Requirements
- R1: Class codes on `cls_o` are: 0 none, 1 upper-immediate, 2 jump, 3 branch, 4 register-immediate arithmetic, 5 register-register arithmetic, 6 load, 7 store, 8 word register-immediate, 9 word register-register, 10 fence, 11 system. An illegal word drives `illegal_o`=1, `cls_o`=0, `op_o`=0, `imm_o`=0, `rd_we_o`=0 and both fence set outputs to 0. Any opcode (bits 6:0) outside 0110111, 0010111, 1101111, 1100111, 1100011, 0010011, 0110011, 0000011, 0100011, 0011011, 0111011, 0001111, 1110011 is illegal.
- R2: `rs1_o`, `rs2_o` and `rd_o` always carry instruction bits 19:15, 24:20 and 11:7, whether or not the word is legal.
- R3: Opcode 0110111 gives class 1, op 0, and opcode 0010111 gives class 1, op 1. The immediate is bits 31:12 followed by twelve zero bits, sign-extended to 64 bits.
- R4: Opcode 1101111 gives class 2, op 0. Its immediate is sign bit 31, then bits 19:12, bit 20 and bits 30:21, then a zero, sign-extended. Opcode 1100111 is legal only with funct3 (bits 14:12) 000 and gives class 2, op 1, with the 12-bit immediate bits 31:20 sign-extended.
- R5: Opcode 1100011 gives class 3 with op equal to funct3 for funct3 000, 001, 100, 101, 110 and 111. Funct3 010 and 011 are illegal. The immediate is bit 31, bit 7, bits 30:25 and bits 11:8, then a zero, sign-extended.
- R6: Arithmetic op codes are: 0 add, 1 subtract, 2 shift left, 3 set-less-signed, 4 set-less-unsigned, 5 xor, 6 shift right logical, 7 shift right arithmetic, 8 or, 9 and. For opcode 0010011 (class 4), funct3 000, 010, 011, 100, 110 and 111 select add, set-less-signed, set-less-unsigned, xor, or and and. All of these carry bits 31:20 sign-extended.
- R7: For opcode 0010011, funct3 001 (shift left) needs bits 31:26 = 000000. Funct3 101 needs 000000 (logical) or 010000 (arithmetic). The immediate is the 6-bit amount in bits 25:20, zero-extended. Any other upper pattern is illegal.
- R8: Opcode 0110011 gives class 5 with immediate 0. Funct7 (bits 31:25) 0100000 is legal only with funct3 000 (subtract) and 101 (arithmetic right shift). Every other combination needs funct7 0000000 and maps funct3 as in R6, with 001 shift left and 101 logical right shift.
- R9: Opcode 0000011 gives class 6 with op equal to funct3 for 000 to 110, and 111 is illegal. Opcode 0100011 gives class 7 with op equal to funct3 for 000 to 011, and 1xx is illegal. Loads use the I immediate. Stores use bits 31:25 followed by bits 11:7, sign-extended.
- R10: Opcode 0011011 gives class 8. Funct3 000 is add with the I immediate. Funct3 001 (shift left) needs funct7 0000000. Funct3 101 needs 0000000 (logical) or 0100000 (arithmetic). Shifts carry the 5-bit amount in bits 24:20, zero-extended. All other funct3 values are illegal.
- R11: Opcode 0111011 gives class 9 with immediate 0. Only add (funct3 000, funct7 0000000), subtract (000, 0100000), shift left (001, 0000000), logical right (101, 0000000) and arithmetic right (101, 0100000) are legal.
- R12: Opcode 0001111 with funct3 000 gives class 10, op 0, and needs bits 31:28, rs1 and rd all zero. It outputs bits 27:24 on `fence_pred_o` and bits 23:20 on `fence_succ_o`. Funct3 001 gives class 10, op 1, and needs bits 31:15 and rd zero. Fence sets are 0 for every other word.
- R13: Opcode 1110011 is legal only as word 0x00000073 (class 11, op 0) or 0x00100073 (class 11, op 1), with immediate 0.
- R14: `rd_we_o` is 1 exactly for legal words of classes 1, 2, 4, 5, 6, 8 and 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| cls_o | output | 4 | Instruction class code |
| op_o | output | 4 | Operation code within the class |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| rd_o | output | 5 | Destination register index |
| imm_o | output | XLEN (64) | Assembled, extended immediate |
| fence_pred_o | output | 4 | Fence predecessor set |
| fence_succ_o | output | 4 | Fence successor set |
| rd_we_o | output | 1 | Destination register write enable |
| illegal_o | output | 1 | Word matches no legal pattern |

## Verification
Each instruction group is tried with legal words whose immediate bits are set in uneven patterns: a lone sign bit, a lone middle bit, or runs of ones in one field only. These show whether each scrambled immediate fragment lands at its correct weight and whether the sign fills the upper bits. Alongside these go near-miss words that differ from a legal encoding in a single funct3, funct7, upper-shift or reserved bit. They tell a decoder that checks the whole pattern apart from one that looks only at the opcode. A sweep of all 128 opcodes with every other bit zero separates the thirteen defined major opcodes from the rest.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

  typedef enum logic [3:0] {
    CLS_NONE   = 4'd0,
    CLS_UPPER  = 4'd1,
    CLS_JUMP   = 4'd2,
    CLS_BRANCH = 4'd3,
    CLS_ALUI   = 4'd4,
    CLS_ALU    = 4'd5,
    CLS_LOAD   = 4'd6,
    CLS_STORE  = 4'd7,
    CLS_ALUIW  = 4'd8,
    CLS_ALUW   = 4'd9,
    CLS_FENCE  = 4'd10,
    CLS_SYS    = 4'd11
  } cls_e;

  localparam logic [3:0] ALU_ADD  = 4'd0;
  localparam logic [3:0] ALU_SUB  = 4'd1;
  localparam logic [3:0] ALU_SLL  = 4'd2;
  localparam logic [3:0] ALU_SLT  = 4'd3;
  localparam logic [3:0] ALU_SLTU = 4'd4;
  localparam logic [3:0] ALU_XOR  = 4'd5;
  localparam logic [3:0] ALU_SRL  = 4'd6;
  localparam logic [3:0] ALU_SRA  = 4'd7;
  localparam logic [3:0] ALU_OR   = 4'd8;
  localparam logic [3:0] ALU_AND  = 4'd9;

  typedef enum logic [2:0] {
    IMM_ZERO = 3'd0,
    IMM_I    = 3'd1,
    IMM_S    = 3'd2,
    IMM_B    = 3'd3,
    IMM_U    = 3'd4,
    IMM_J    = 3'd5,
    IMM_SH6  = 3'd6,
    IMM_SH5  = 3'd7
  } immk_e;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_ALUI   = 7'b0010011;
  localparam logic [6:0] OPC_ALU    = 7'b0110011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_ALUIW  = 7'b0011011;
  localparam logic [6:0] OPC_ALUW   = 7'b0111011;
  localparam logic [6:0] OPC_FENCE  = 7'b0001111;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  typedef struct packed {
    cls_e       cls;
    logic [3:0] op;
    immk_e      immk;
    logic       wr;
    logic       bad;
  } ctrl_t;

  // Shared funct3 -> arithmetic op mapping; alt picks subtract / arithmetic shift
  function automatic logic [3:0] alu_of(input logic [2:0] f3, input logic alt);
    logic [3:0] r;
    case (f3)
      3'b000:  r = alt ? ALU_SUB : ALU_ADD;
      3'b001:  r = ALU_SLL;
      3'b010:  r = ALU_SLT;
      3'b011:  r = ALU_SLTU;
      3'b100:  r = ALU_XOR;
      3'b101:  r = alt ? ALU_SRA : ALU_SRL;
      3'b110:  r = ALU_OR;
      default: r = ALU_AND;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
  import rvdec_pkg::*;
(
  input  logic [31:0] instr_i,
  output ctrl_t       ctl_o
);

  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic [5:0] top6;
  logic [4:0] rs1;
  logic [4:0] rd;

  assign opc  = instr_i[6:0];
  assign f3   = instr_i[14:12];
  assign f7   = instr_i[31:25];
  assign top6 = instr_i[31:26];
  assign rs1  = instr_i[19:15];
  assign rd   = instr_i[11:7];

  logic       ok;
  cls_e       cls;
  logic [3:0] op;
  immk_e      immk;
  logic       alt;

  always_comb begin
    ok   = 1'b0;
    cls  = CLS_NONE;
    op   = 4'd0;
    immk = IMM_ZERO;
    alt  = 1'b0;
    case (opc)
      OPC_LUI: begin
        ok = 1'b1; cls = CLS_UPPER; op = 4'd0; immk = IMM_U;
      end
      OPC_AUIPC: begin
        ok = 1'b1; cls = CLS_UPPER; op = 4'd1; immk = IMM_U;
      end
      OPC_JAL: begin
        ok = 1'b1; cls = CLS_JUMP; op = 4'd0; immk = IMM_J;
      end
      OPC_JALR: begin
        ok = (f3 == 3'b000); cls = CLS_JUMP; op = 4'd1; immk = IMM_I;
      end
      OPC_BRANCH: begin
        ok = (f3[2:1] != 2'b01); cls = CLS_BRANCH; op = {1'b0, f3}; immk = IMM_B;
      end
      OPC_ALUI: begin
        cls = CLS_ALUI;
        case (f3)
          3'b001: begin
            ok = (top6 == 6'b000000); immk = IMM_SH6;
          end
          3'b101: begin
            alt = (top6 == 6'b010000);
            ok  = (top6 == 6'b000000) || alt;
            immk = IMM_SH6;
          end
          default: begin
            ok = 1'b1; immk = IMM_I;
          end
        endcase
        op = alu_of(f3, alt);
      end
      OPC_ALU: begin
        cls  = CLS_ALU;
        immk = IMM_ZERO;
        alt  = (f7 == F7_ALT) && (f3 == 3'b000 || f3 == 3'b101);
        ok   = (f7 == F7_BASE) || alt;
        op   = alu_of(f3, alt);
      end
      OPC_LOAD: begin
        ok = (f3 != 3'b111); cls = CLS_LOAD; op = {1'b0, f3}; immk = IMM_I;
      end
      OPC_STORE: begin
        ok = !f3[2]; cls = CLS_STORE; op = {1'b0, f3}; immk = IMM_S;
      end
      OPC_ALUIW: begin
        cls = CLS_ALUIW;
        case (f3)
          3'b000: begin
            ok = 1'b1; immk = IMM_I;
          end
          3'b001: begin
            ok = (f7 == F7_BASE); immk = IMM_SH5;
          end
          3'b101: begin
            alt = (f7 == F7_ALT);
            ok  = (f7 == F7_BASE) || alt;
            immk = IMM_SH5;
          end
          default: ok = 1'b0;
        endcase
        op = alu_of(f3, alt);
      end
      OPC_ALUW: begin
        cls  = CLS_ALUW;
        immk = IMM_ZERO;
        alt  = (f7 == F7_ALT) && (f3 == 3'b000 || f3 == 3'b101);
        ok   = ((f7 == F7_BASE) || alt) &&
               (f3 == 3'b000 || f3 == 3'b001 || f3 == 3'b101);
        op   = alu_of(f3, alt);
      end
      OPC_FENCE: begin
        cls = CLS_FENCE;
        if (f3 == 3'b000) begin
          ok = (instr_i[31:28] == 4'd0) && (rs1 == 5'd0) && (rd == 5'd0);
          op = 4'd0;
        end else if (f3 == 3'b001) begin
          ok = (instr_i[31:15] == 17'd0) && (rd == 5'd0);
          op = 4'd1;
        end else begin
          ok = 1'b0;
        end
      end
      OPC_SYSTEM: begin
        cls = CLS_SYS;
        ok  = (instr_i[31:21] == 11'd0) && (instr_i[19:7] == 13'd0);
        op  = {3'b000, instr_i[20]};
      end
      default: ok = 1'b0;
    endcase
  end

  // Illegal words collapse to a bubble
  always_comb begin
    ctl_o.bad  = !ok;
    ctl_o.cls  = ok ? cls : CLS_NONE;
    ctl_o.op   = ok ? op : 4'd0;
    ctl_o.immk = ok ? immk : IMM_ZERO;
    ctl_o.wr   = ok && (cls inside {CLS_UPPER, CLS_JUMP, CLS_ALUI, CLS_ALU,
                                   CLS_LOAD, CLS_ALUIW, CLS_ALUW});
  end

endmodule

// File: rtl/rvdec_imm.sv
module rvdec_imm
  import rvdec_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:7]     instr_i,
  input  immk_e           immk_i,
  output logic [XLEN-1:0] imm_o
);

  localparam int PAD_I  = XLEN - 12;
  localparam int PAD_B  = XLEN - 13;
  localparam int PAD_U  = XLEN - 32;
  localparam int PAD_J  = XLEN - 21;
  localparam int PAD_S6 = XLEN - 6;
  localparam int PAD_S5 = XLEN - 5;

  logic            sgn;
  logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_u, imm_j, imm_sh6, imm_sh5;

  assign sgn = instr_i[31];

  assign imm_i   = {{PAD_I{sgn}}, instr_i[31:20]};
  assign imm_s   = {{PAD_I{sgn}}, instr_i[31:25], instr_i[11:7]};
  assign imm_b   = {{PAD_B{sgn}}, sgn, instr_i[7], instr_i[30:25], instr_i[11:8], 1'b0};
  assign imm_u   = {{PAD_U{sgn}}, instr_i[31:12], 12'd0};
  assign imm_j   = {{PAD_J{sgn}}, sgn, instr_i[19:12], instr_i[20], instr_i[30:21], 1'b0};
  assign imm_sh6 = {{PAD_S6{1'b0}}, instr_i[25:20]};
  assign imm_sh5 = {{PAD_S5{1'b0}}, instr_i[24:20]};

  always_comb begin
    case (immk_i)
      IMM_I:   imm_o = imm_i;
      IMM_S:   imm_o = imm_s;
      IMM_B:   imm_o = imm_b;
      IMM_U:   imm_o = imm_u;
      IMM_J:   imm_o = imm_j;
      IMM_SH6: imm_o = imm_sh6;
      IMM_SH5: imm_o = imm_sh5;
      default: imm_o = '0;
    endcase
  end

endmodule

// File: rtl/rvdec_top.sv
module rvdec_top
  import rvdec_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0]     instr_i,
  output logic [3:0]      cls_o,
  output logic [3:0]      op_o,
  output logic [4:0]      rs1_o,
  output logic [4:0]      rs2_o,
  output logic [4:0]      rd_o,
  output logic [XLEN-1:0] imm_o,
  output logic [3:0]      fence_pred_o,
  output logic [3:0]      fence_succ_o,
  output logic            rd_we_o,
  output logic            illegal_o
);

  ctrl_t ctl;

  rvdec_ctrl u_ctrl (
    .instr_i (instr_i),
    .ctl_o   (ctl)
  );

  rvdec_imm #(.XLEN(XLEN)) u_imm (
    .instr_i (instr_i[31:7]),
    .immk_i  (ctl.immk),
    .imm_o   (imm_o)
  );

  logic is_fence;
  assign is_fence = (ctl.cls == CLS_FENCE) && (ctl.op == 4'd0);

  assign cls_o        = ctl.cls;
  assign op_o         = ctl.op;
  assign rd_we_o      = ctl.wr;
  assign illegal_o    = ctl.bad;
  assign rs1_o        = instr_i[19:15];
  assign rs2_o        = instr_i[24:20];
  assign rd_o         = instr_i[11:7];
  assign fence_pred_o = is_fence ? instr_i[27:24] : 4'd0;
  assign fence_succ_o = is_fence ? instr_i[23:20] : 4'd0;

  // Cross-checks between the control path and the immediate path
  always_comb begin
    if (!$isunknown(instr_i)) begin
      if (illegal_o) begin
        assert_illegal_quiet_R1: assert (cls_o == 4'd0 && op_o == 4'd0 && !rd_we_o &&
                                         imm_o == '0 && fence_pred_o == 4'd0)
          else $error("illegal word left live outputs");
      end
      if (cls_o == CLS_UPPER) begin
        assert_upper_low_zero_R3: assert (imm_o[11:0] == 12'd0)
          else $error("upper immediate has nonzero low bits");
      end
      if (cls_o == CLS_BRANCH || (cls_o == CLS_JUMP && op_o == 4'd0)) begin
        assert_target_even_R5: assert (imm_o[0] == 1'b0)
          else $error("branch or jump offset is odd");
      end
      if (cls_o == CLS_ALUIW && op_o != ALU_ADD) begin
        assert_wshift_range_R10: assert (imm_o < XLEN'(32))
          else $error("word shift amount exceeds 31");
      end
      if (cls_o == CLS_ALUI && (op_o == ALU_SLL || op_o == ALU_SRL || op_o == ALU_SRA)) begin
        assert_shift_range_R7: assert (imm_o < XLEN'(64))
          else $error("shift amount exceeds 63");
      end
      if (cls_o == CLS_STORE || cls_o == CLS_BRANCH || cls_o == CLS_FENCE ||
          cls_o == CLS_SYS) begin
        assert_nowrite_R14: assert (!rd_we_o)
          else $error("write enabled for a non-writing class");
      end
      if (fence_pred_o != 4'd0 || fence_succ_o != 4'd0) begin
        assert_fence_sets_R12: assert (cls_o == CLS_FENCE && op_o == 4'd0)
          else $error("fence sets outside a fence");
      end
    end
  end

endmodule

// File: tb/rvdec_top_test.sv
`timescale 1ns/1ps
module rvdec_top_test;

  logic clk;
  logic rst_n;
  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] instr;
  logic [3:0]  cls, op, pred, succ;
  logic [4:0]  rs1, rs2, rd;
  logic [63:0] imm;
  logic        we, ill;

  rvdec_top #(.XLEN(64)) uut (
    .instr_i      (instr),
    .cls_o        (cls),
    .op_o         (op),
    .rs1_o        (rs1),
    .rs2_o        (rs2),
    .rd_o         (rd),
    .imm_o        (imm),
    .fence_pred_o (pred),
    .fence_succ_o (succ),
    .rd_we_o      (we),
    .illegal_o    (ill)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0]  rq;
    logic [31:0] w;
    logic [3:0]  c;
    logic [3:0]  o;
    logic        we;
    logic        il;
    logic [63:0] im;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VT [NV] = '{
    '{4'd3,  32'h800002B7, 4'd1,  4'd0, 1'b1, 1'b0, 64'hFFFFFFFF80000000}, // R3 upper, sign fill
    '{4'd3,  32'h12345097, 4'd1,  4'd1, 1'b1, 1'b0, 64'h0000000012345000}, // R3 pc-relative upper
    '{4'd4,  32'h801000EF, 4'd2,  4'd0, 1'b1, 1'b0, 64'hFFFFFFFFFFF00800}, // R4 jump: sign + bit 20
    '{4'd4,  32'h7FEAB06F, 4'd2,  4'd0, 1'b1, 1'b0, 64'h00000000000AB7FE}, // R4 jump: 30:21 and 19:12
    '{4'd4,  32'hFFC100E7, 4'd2,  4'd1, 1'b1, 1'b0, 64'hFFFFFFFFFFFFFFFC}, // R4 register jump
    '{4'd4,  32'hFFC110E7, 4'd0,  4'd0, 1'b0, 1'b1, 64'h0},                // R4 register jump bad funct3
    '{4'd5,  32'h80321063, 4'd3,  4'd1, 1'b0, 1'b0, 64'hFFFFFFFFFFFFF000}, // R5 not-equal, sign only
    '{4'd5,  32'h7E007FE3, 4'd3,  4'd7, 1'b0, 1'b0, 64'h0000000000000FFE}, // R5 unsigned ge, bit 7 -> 11
    '{4'd5,  32'h00002063, 4'd0,  4'd0, 1'b0, 1'b1, 64'h0},                // R5 funct3 010
    '{4'd6,  32'hFFF00093, 4'd4,  4'd0, 1'b1, 1'b0, 64'hFFFFFFFFFFFFFFFF}, // R6 add -1
    '{4'd6,  32'h00103113, 4'd4,  4'd4, 1'b1, 1'b0, 64'h1},                // R6 set-less-unsigned
    '{4'd6,  32'h7FF07013, 4'd4,  4'd9, 1'b1, 1'b0, 64'h7FF},              // R6 and, max positive
    '{4'd7,  32'h03F01013, 4'd4,  4'd2, 1'b1, 1'b0, 64'h3F},               // R7 shift left 63
    '{4'd7,  32'h42105013, 4'd4,  4'd7, 1'b1, 1'b0, 64'h21},               // R7 arith right 33
    '{4'd7,  32'h04005013, 4'd0,  4'd0, 1'b0, 1'b1, 64'h0},                // R7 bad upper pattern
    '{4'd8,  32'h002081B3, 4'd5,  4'd0, 1'b1, 1'b0, 64'h0},                // R8 add
    '{4'd8,  32'h402081B3, 4'd5,  4'd1, 1'b1, 1'b0, 64'h0},                // R8 subtract
    '{4'd8,  32'h4020D1B3, 4'd5,  4'd7, 1'b1, 1'b0, 64'h0},                // R8 arith right
    '{4'd8,  32'h4020C1B3, 4'd0,  4'd0, 1'b0, 1'b1, 64'h0},                // R8 xor with alt funct7
    '{4'd9,  32'hFF80B083, 4'd6,  4'd3, 1'b1, 1'b0, 64'hFFFFFFFFFFFFFFF8}, // R9 double load
    '{4'd9,  32'h0000E003, 4'd6,  4'd6, 1'b1, 1'b0, 64'h0},                // R9 unsigned word load
    '{4'd9,  32'h0000F003, 4'd0,  4'd0, 1'b0, 1'b1, 64'h0},                // R9 load funct3 111
    '{4'd9,  32'h805130A3, 4'd7,  4'd3, 1'b0, 1'b0, 64'hFFFFFFFFFFFFF801}, // R9 double store split imm
    '{4'd9,  32'h00004023, 4'd0,  4'd0, 1'b0, 1'b1, 64'h0},                // R9 store funct3 100
    '{4'd10, 32'h8000001B, 4'd8,  4'd0, 1'b1, 1'b0, 64'hFFFFFFFFFFFFF800}, // R10 word add imm
    '{4'd10, 32'h01F0101B, 4'd8,  4'd2, 1'b1, 1'b0, 64'h1F},               // R10 word shift left 31
    '{4'd10, 32'h4050501B, 4'd8,  4'd7, 1'b1, 1'b0, 64'h5},                // R10 word arith right 5
    '{4'd10, 32'h0200101B, 4'd0,  4'd0, 1'b0, 1'b1, 64'h0},                // R10 amount bit 5 set
    '{4'd10, 32'h0000201B, 4'd0,  4'd0, 1'b0, 1'b1, 64'h0},                // R10 funct3 010
    '{4'd11, 32'h402081BB, 4'd9,  4'd1, 1'b1, 1'b0, 64'h0},                // R11 word subtract
    '{4'd11, 32'h0020D1BB, 4'd9,  4'd6, 1'b1, 1'b0, 64'h0},                // R11 word logical right
    '{4'd11, 32'h0020C1BB, 4'd0,  4'd0, 1'b0, 1'b1, 64'h0},                // R11 word xor absent
    '{4'd12, 32'h0F30000F, 4'd10, 4'd0, 1'b0, 1'b0, 64'h0},                // R12 fence sets F/3
    '{4'd12, 32'h8F30000F, 4'd0,  4'd0, 1'b0, 1'b1, 64'h0},                // R12 top bits set
    '{4'd12, 32'h0000100F, 4'd10, 4'd1, 1'b0, 1'b0, 64'h0},                // R12 instruction fence
    '{4'd12, 32'h0000108F, 4'd0,  4'd0, 1'b0, 1'b1, 64'h0},                // R12 instr fence with rd
    '{4'd12, 32'h0F30800F, 4'd0,  4'd0, 1'b0, 1'b1, 64'h0},                // R12 fence with rs1
    '{4'd13, 32'h00000073, 4'd11, 4'd0, 1'b0, 1'b0, 64'h0},                // R13 environment call
    '{4'd13, 32'h00100073, 4'd11, 4'd1, 1'b0, 1'b0, 64'h0},                // R13 breakpoint
    '{4'd13, 32'h00200073, 4'd0,  4'd0, 1'b0, 1'b1, 64'h0},                // R13 other system word
    '{4'd1,  32'h0000007F, 4'd0,  4'd0, 1'b0, 1'b1, 64'h0},                // R1 undefined opcode
    '{4'd1,  32'h00000000, 4'd0,  4'd0, 1'b0, 1'b1, 64'h0}                 // R1 all-zero word
  };

  function automatic bit legal_major(input logic [6:0] o);
    return o inside {7'b0110111, 7'b0010111, 7'b1101111, 7'b1100111, 7'b1100011,
                     7'b0010011, 7'b0110011, 7'b0000011, 7'b0100011, 7'b0011011,
                     7'b0111011, 7'b0001111, 7'b1110011};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    string tag;
    rst_n = 1'b0;
    instr = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // Reset-time state: the all-zero word must decode as a bubble (R1)
    chk("R1", "reset illegal", {63'd0, ill}, 64'd1);
    chk("R1", "reset write enable", {63'd0, we}, 64'd0);
    chk("R1", "reset class", {60'd0, cls}, 64'd0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      instr = VT[k].w;
      #2;
      tag = $sformatf("R%0d", VT[k].rq);
      chk(tag, "class", {60'd0, cls}, {60'd0, VT[k].c});
      chk(tag, "op", {60'd0, op}, {60'd0, VT[k].o});
      chk(tag, "imm", imm, VT[k].im);
      chk(tag, "illegal", {63'd0, ill}, {63'd0, VT[k].il});
      chk("R14", "write enable", {63'd0, we}, {63'd0, VT[k].we});
      chk("R2", "rs1", {59'd0, rs1}, {59'd0, VT[k].w[19:15]});
      chk("R2", "rs2", {59'd0, rs2}, {59'd0, VT[k].w[24:20]});
      chk("R2", "rd", {59'd0, rd}, {59'd0, VT[k].w[11:7]});
      if (VT[k].c == 4'd10 && VT[k].o == 4'd0 && !VT[k].il) begin
        chk("R12", "pred", {60'd0, pred}, {60'd0, VT[k].w[27:24]});
        chk("R12", "succ", {60'd0, succ}, {60'd0, VT[k].w[23:20]});
      end else begin
        chk("R12", "pred zero", {60'd0, pred}, 64'd0);
        chk("R12", "succ zero", {60'd0, succ}, 64'd0);
      end
    end

    // R1: sweep every major opcode with all other bits zero
    for (int o = 0; o < 128; o++) begin
      @(negedge clk);
      instr = {25'd0, 7'(o)};
      #2;
      chk("R1", $sformatf("opcode sweep %02h", o), {63'd0, ill},
          {63'd0, !legal_major(7'(o))});
    end

    // R2: register fields pass through even on an illegal word
    @(negedge clk);
    instr = 32'hFFFFFFFF;
    #2;
    chk("R2", "illegal rs1", {59'd0, rs1}, 64'd31);
    chk("R2", "illegal rd", {59'd0, rd}, 64'd31);
    chk("R1", "all-ones illegal", {63'd0, ill}, 64'd1);
    chk("R1", "all-ones imm", imm, 64'd0);

    // R7: shift left with the arithmetic upper pattern is not a shift right
    @(negedge clk);
    instr = 32'h40001013;
    #2;
    chk("R7", "shift left alt pattern", {63'd0, ill}, 64'd1);

    // R4: register jump immediate positive maximum
    @(negedge clk);
    instr = 32'h7FF00067;
    #2;
    chk("R4", "jalr max imm", imm, 64'h7FF);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule